// File: doc/BRIEF.md
# Multilevel Priority Interrupt Controller

This block decides which of a parameterized set of interrupt lines gets the CPU next. Each line has its own enable bit and a two-bit level code. There are three maskable levels (low, medium, high), and a non-maskable request ranks above all of them. The controller keeps one in-service bit per level. A request reaches the CPU only when its level ranks strictly above every level already being serviced, so interrupt handlers nest by level.

The CPU side is a small handshake. The controller raises `irq_valid` with a vector word address. The CPU accepts it with `ack` and later reports the end of the handler with `reti`. Among the lines of one level, the lowest vector address wins. For the low level only, a round-robin mode can be switched on: the search then starts just after the most recently acknowledged low-level line.

The handshake runs as a two-state machine.
- `ST_IDLE`: nothing is offered.
- `ST_OFFER`: a vector is presented.

Its transitions:
- RAISE (`ST_IDLE` to `ST_OFFER`): a request is eligible.
- HOLD (`ST_OFFER` to `ST_OFFER`): an eligible request remains. The vector may change to a new winner.
- WITHDRAW (`ST_OFFER` to `ST_IDLE`): the offer was acknowledged, or it was masked or dropped, and nothing else is eligible.

Top module: `mlv_irq_ctrl`

## Requirements
- R1: After reset, `irq_valid` is 0 and no level is in service.
- R2: A line takes part in arbitration only when all three of the following hold:
  - its `line_en` bit is 1;
  - its level code is nonzero (01 low, 10 medium, 11 high, 00 off);
  - the global enable bit of its level in `lvl_en` is 1 (bit 0 low, bit 1 medium, bit 2 high).
  A line that fails any of these, or whose request is removed, is not offered.
- R3: Among the eligible lines of one level, the lowest line index wins. Its vector is `VEC_BASE + index*VEC_STRIDE` (by default 4 + 2*index).
- R4: A request is offered only if its level ranks strictly above the highest level in service. The ranks are low < medium < high < non-maskable, so medium preempts low and high preempts both.
- R5: `ack` while `irq_valid` is 1 sets the in-service bit of the offered level. `ack` while `irq_valid` is 0 has no effect. `reti` clears only the highest set in-service bit.
- R6: `nmi_req` wins over every maskable level with vector `NMI_VEC` (default 2). No enable masks it. It is held off only while a non-maskable handler is in service.
- R7: With `rr_en` at 1, once low-level line k has been acknowledged, the low-level search starts at line k+1 and wraps around. With `rr_en` at 0, the order is fixed. Medium and high never rotate.
- R8: `irq_valid` and `irq_vector` are registered. They reflect the inputs at the previous rising edge, including any `ack` or `reti` taken at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | NUM_VEC | Per-line request |
| line_en | input | NUM_VEC | Per-line enable |
| line_lvl | input | 2*NUM_VEC | Level code of line i in bits [2i+1:2i] |
| lvl_en | input | 3 | Global enable per level (low, medium, high) |
| rr_en | input | 1 | Round-robin mode for the low level |
| nmi_req | input | 1 | Non-maskable request |
| ack | input | 1 | CPU accepts the offered vector |
| reti | input | 1 | CPU returns from the current handler |
| irq_valid | output | 1 | A vector is offered |
| irq_vector | output | ADDR_W | Word address of the offered vector |

## Verification
Every result is due at the first rising edge after its stimulus, because one register stage sits between the inputs and the outputs. An `ack` or `reti` taken at that edge already affects the value offered just after it. The bench changes inputs on a falling edge and queues the expected value after the next rising edge. The monitor compares at the following falling edge. One check also samples before that rising edge, to confirm that no input reaches the outputs without passing through a register.

// File: rtl/mlv_irq_pkg.sv
package mlv_irq_pkg;

    typedef enum logic [1:0] {
        LVL_OFF = 2'b00,
        LVL_LO  = 2'b01,
        LVL_MD  = 2'b10,
        LVL_HI  = 2'b11
    } lvl_e;

    typedef enum logic {
        ST_IDLE,
        ST_OFFER
    } hs_state_e;

    // in-service bit positions: 0 low, 1 medium, 2 high, 3 non-maskable
    localparam int NUM_SVC = 4;

    // rank of highest set in-service bit: 0 none, 1 low .. 4 non-maskable
    function automatic logic [2:0] top_rank(input logic [NUM_SVC-1:0] s);
        logic [2:0] r;
        r = 3'd0;
        for (int b = 0; b < NUM_SVC; b++) begin
            if (s[b]) r = 3'(b + 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/mlv_irq_level_arb.sv
module mlv_irq_level_arb #(
    parameter int NUM_VEC = 8,
    parameter bit RR_CAP  = 1'b0,
    localparam int IW     = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] req,
    input  logic               rr_en,
    input  logic [IW-1:0]      last,
    output logic               found,
    output logic [IW-1:0]      idx
);

    logic [NUM_VEC-1:0] grant;
    int start;
    int pos;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        start = 0;
        pos   = 0;
        if (RR_CAP && rr_en) start = (int'(last) + 1) % NUM_VEC;
        for (int k = 0; k < NUM_VEC; k++) begin
            pos = (start + k) % NUM_VEC;
            if (!found && req[pos]) begin
                found = 1'b1;
                idx   = IW'(pos);
            end
        end
    end

    assign grant = found ? (NUM_VEC'(1) << idx) : '0;

    assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (found == (req != '0)));

    assert_grant_in_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);

endmodule

// File: rtl/mlv_irq_service.sv
module mlv_irq_service
    import mlv_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ack_set,
    input  logic [1:0]         ack_bit,
    input  logic               reti,
    output logic [NUM_SVC-1:0] svc_q,
    output logic [NUM_SVC-1:0] svc_nx
);

    int hi;

    always_comb begin
        svc_nx = svc_q;
        hi = -1;
        for (int b = 0; b < NUM_SVC; b++) begin
            if (svc_q[b]) hi = b;
        end
        if (reti && hi >= 0) svc_nx[hi] = 1'b0;
        if (ack_set) svc_nx[ack_bit] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) svc_q <= '0;
        else        svc_q <= svc_nx;
    end

    assert_reti_clears_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !ack_set && svc_q != '0) |=>
        ($countones(svc_q) == $countones($past(svc_q)) - 1) &&
        (top_rank(svc_q) < top_rank($past(svc_q))));

    assert_ack_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_set && !reti) |=> svc_q[$past(ack_bit)]);

endmodule

// File: rtl/mlv_irq_ctrl.sv
module mlv_irq_ctrl
    import mlv_irq_pkg::*;
#(
    parameter int NUM_VEC    = 8,
    parameter int ADDR_W     = 16,
    parameter int VEC_BASE   = 4,
    parameter int VEC_STRIDE = 2,
    parameter int NMI_VEC    = 2,
    localparam int IW        = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
    localparam int NUM_LVL   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_VEC-1:0]   irq_req,
    input  logic [NUM_VEC-1:0]   line_en,
    input  logic [2*NUM_VEC-1:0] line_lvl,
    input  logic [NUM_LVL-1:0]   lvl_en,
    input  logic                 rr_en,
    input  logic                 nmi_req,
    input  logic                 ack,
    input  logic                 reti,
    output logic                 irq_valid,
    output logic [ADDR_W-1:0]    irq_vector
);

    hs_state_e          state, state_nx;
    logic [1:0]         win_bit_q, pick_bit;
    logic [IW-1:0]      win_idx_q, pick_idx;
    logic               pick_ok;
    logic [IW-1:0]      last_q, last_nx;
    logic               ack_take;
    logic [NUM_SVC-1:0] svc_q, svc_nx;
    logic [2:0]         cur_rank;

    logic [NUM_VEC-1:0] lv_req   [NUM_LVL];
    logic [NUM_LVL-1:0] lv_found;
    logic [IW-1:0]      lv_idx   [NUM_LVL];

    // per-level request masks
    always_comb begin
        for (int l = 0; l < NUM_LVL; l++) begin
            for (int i = 0; i < NUM_VEC; i++) begin
                lv_req[l][i] = irq_req[i] & line_en[i] & lvl_en[l] &
                               (line_lvl[2*i +: 2] == 2'(l + 1));
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
            mlv_irq_level_arb #(
                .NUM_VEC (NUM_VEC),
                .RR_CAP  (g == 0)
            ) u_arb (
                .clk   (clk),
                .rst_n (rst_n),
                .req   (lv_req[g]),
                .rr_en (rr_en),
                .last  (last_nx),
                .found (lv_found[g]),
                .idx   (lv_idx[g])
            );
        end
    endgenerate

    assign ack_take = ack && (state == ST_OFFER);

    mlv_irq_service u_svc (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack_set (ack_take),
        .ack_bit (win_bit_q),
        .reti    (reti),
        .svc_q   (svc_q),
        .svc_nx  (svc_nx)
    );

    // round-robin pointer follows the last taken low-level line
    assign last_nx = (ack_take && win_bit_q == 2'd0) ? win_idx_q : last_q;

    // pick against the in-service set as it stands after this edge
    always_comb begin
        cur_rank = top_rank(svc_nx);
        pick_ok  = 1'b0;
        pick_bit = 2'd0;
        pick_idx = '0;
        if (nmi_req && cur_rank < 3'd4) begin
            pick_ok  = 1'b1;
            pick_bit = 2'd3;
        end else begin
            for (int l = 0; l < NUM_LVL; l++) begin
                if (lv_found[l] && cur_rank < 3'(l + 1)) begin
                    pick_ok  = 1'b1;
                    pick_bit = 2'(l);
                    pick_idx = lv_idx[l];
                end
            end
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  state_nx = pick_ok ? ST_OFFER : ST_IDLE;   // RAISE
            ST_OFFER: state_nx = pick_ok ? ST_OFFER : ST_IDLE;   // HOLD / WITHDRAW
        endcase
    end

    // state register with the winner it offers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            win_bit_q <= 2'd0;
            win_idx_q <= '0;
            last_q    <= IW'(NUM_VEC - 1);
        end else begin
            state     <= state_nx;
            win_bit_q <= pick_bit;
            win_idx_q <= pick_idx;
            last_q    <= last_nx;
        end
    end

    // outputs
    always_comb begin
        irq_valid  = (state == ST_OFFER);
        irq_vector = (win_bit_q == 2'd3) ? ADDR_W'(NMI_VEC)
                   : ADDR_W'(VEC_BASE) + ADDR_W'(win_idx_q) * ADDR_W'(VEC_STRIDE);
    end

    assert_offer_outranks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> ((3'(win_bit_q) + 3'd1) > top_rank(svc_q)));

    assert_nmi_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && !svc_nx[3]) |=> (irq_valid && win_bit_q == 2'd3));

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_q == '0 && !irq_valid && !ack && !reti) |=> (svc_q == '0));

endmodule

// File: tb/test_mlv_irq_ctrl.sv
module test_mlv_irq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    irq_req = '0;
    logic [N-1:0]    line_en = '1;
    logic [2*N-1:0]  line_lvl;
    logic [2:0]      lvl_en = 3'b111;
    logic            rr_en = 1'b0;
    logic            nmi_req = 1'b0;
    logic            ack = 1'b0;
    logic            reti = 1'b0;
    logic            irq_valid;
    logic [15:0]     irq_vector;

    int total = 0;
    int bad = 0;

    typedef struct {
        bit          v;
        logic [15:0] vec;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mlv_irq_ctrl #(.NUM_VEC(N)) i_mlv_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .line_en(line_en),
        .line_lvl(line_lvl), .lvl_en(lvl_en), .rr_en(rr_en), .nmi_req(nmi_req),
        .ack(ack), .reti(reti), .irq_valid(irq_valid), .irq_vector(irq_vector)
    );

    function automatic logic [15:0] vec_of(input int i);
        return 16'(4 + 2*i);
    endfunction

    task automatic set_lvl(input int i, input logic [1:0] l);
        line_lvl[2*i +: 2] = l;
    endtask

    // driver: expectation is due right after the next rising edge
    task automatic step(input bit v, input logic [15:0] vec, input string tag);
        exp_t e;
        @(posedge clk);
        e.v = v; e.vec = vec; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    task automatic pulse_ack(input bit v, input logic [15:0] vec, input string tag);
        ack = 1'b1;
        step(v, vec, tag);
        ack = 1'b0;
    endtask

    task automatic pulse_reti(input bit v, input logic [15:0] vec, input string tag);
        reti = 1'b1;
        step(v, vec, tag);
        reti = 1'b0;
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                total++;
                if (irq_valid !== e.v || (e.v && irq_vector !== e.vec)) begin
                    bad++;
                    $display("FAIL %s: valid=%0b vector=%0d expected valid=%0b vector=%0d",
                             e.tag, irq_valid, irq_vector, e.v, e.vec);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R8 watchdog: run hung, actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) line_lvl[2*i +: 2] = 2'b01;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        step(0, 0, "R1 idle after reset");

        // basic low arbitration and register stage
        irq_req[3] = 1'b1; irq_req[5] = 1'b1;
        total++;
        if (irq_valid !== 1'b0) begin
            bad++;
            $display("FAIL R8 before edge: valid=%0b expected valid=0", irq_valid);
        end
        step(1, vec_of(3), "R3 R8 lowest low line offered after one edge");
        pulse_ack(0, 0, "R5 low in service blocks low");
        irq_req[3] = 1'b0;

        // nesting
        set_lvl(6, 2'b10); irq_req[6] = 1'b1;
        step(1, vec_of(6), "R4 medium preempts low");
        pulse_ack(0, 0, "R5 medium taken");
        irq_req[6] = 1'b0;
        set_lvl(7, 2'b11); irq_req[7] = 1'b1;
        step(1, vec_of(7), "R4 high preempts medium");
        pulse_ack(0, 0, "R5 high taken");
        irq_req[7] = 1'b0;
        nmi_req = 1'b1;
        step(1, 16'd2, "R6 non-maskable above high");
        pulse_ack(0, 0, "R6 non-maskable does not nest on itself");
        nmi_req = 1'b0;
        set_lvl(2, 2'b11); irq_req[2] = 1'b1;
        step(0, 0, "R4 high held off under non-maskable");
        pulse_reti(0, 0, "R5 reti clears only non-maskable, high still in service");
        pulse_reti(1, vec_of(2), "R5 second reti frees high level");
        pulse_ack(0, 0, "R5 high taken again");
        irq_req[2] = 1'b0;
        pulse_reti(0, 0, "R5 medium still in service");
        pulse_reti(0, 0, "R5 low still in service");
        pulse_reti(1, vec_of(5), "R5 low done, pending low offered");
        pulse_ack(0, 0, "R5 low taken");
        irq_req[5] = 1'b0;
        pulse_reti(0, 0, "R1 all levels idle");

        // masking
        set_lvl(1, 2'b11); line_en[1] = 1'b0; irq_req[1] = 1'b1;
        step(0, 0, "R2 line enable clear");
        line_en[1] = 1'b1;
        step(1, vec_of(1), "R2 line enabled");
        set_lvl(1, 2'b00);
        step(0, 0, "R2 level code off");
        set_lvl(1, 2'b10); lvl_en[1] = 1'b0;
        step(0, 0, "R2 medium global disable");
        lvl_en = 3'b111;
        step(1, vec_of(1), "R2 medium re-enabled");
        irq_req[1] = 1'b0;
        set_lvl(6, 2'b11); irq_req[6] = 1'b1; irq_req[2] = 1'b1;
        step(1, vec_of(2), "R3 same-level tie at high");
        irq_req[6] = 1'b0; irq_req[2] = 1'b0;
        step(0, 0, "R2 withdrawn request not offered");

        // fixed order then round-robin
        set_lvl(1, 2'b01); set_lvl(4, 2'b01); set_lvl(6, 2'b01);
        irq_req[1] = 1'b1; irq_req[4] = 1'b1; irq_req[6] = 1'b1;
        step(1, vec_of(1), "R3 fixed low order");
        pulse_ack(0, 0, "R5 low taken");
        pulse_reti(1, vec_of(1), "R7 fixed order repeats line 1");
        rr_en = 1'b1;
        step(1, vec_of(4), "R7 rotation starts after line 1");
        pulse_ack(0, 0, "R5 low taken");
        pulse_reti(1, vec_of(6), "R7 next after line 4");
        pulse_ack(0, 0, "R5 low taken");
        pulse_reti(1, vec_of(1), "R7 wrap to line 1");
        pulse_ack(0, 0, "R5 low taken");
        pulse_reti(1, vec_of(4), "R7 rotation continues");
        irq_req = '0;
        set_lvl(0, 2'b10); set_lvl(3, 2'b10);
        irq_req[0] = 1'b1; irq_req[3] = 1'b1;
        step(1, vec_of(0), "R3 medium lowest line");
        pulse_ack(0, 0, "R5 medium taken");
        pulse_reti(1, vec_of(0), "R7 medium never rotates");
        pulse_ack(0, 0, "R5 medium taken");
        irq_req = '0;
        pulse_reti(0, 0, "R1 idle again");

        // stray acknowledge
        pulse_ack(0, 0, "R5 ack while idle ignored");
        set_lvl(0, 2'b01); irq_req[0] = 1'b1;
        step(1, vec_of(0), "R5 stray ack left low not in service");

        @(negedge clk);
        #1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule